// File: doc/BRIEF.md
# Special-Purpose Register Decode File

This block is the special-purpose register unit of a small RISC core. A move-to instruction presents a base value and an immediate offset. Their bitwise OR forms a 16-bit register address: a 5-bit group in bits 15:11 and an 11-bit index in bits 10:0. The block writes the word into the selected register. A move-from instruction uses the same address to return the selected value. The block holds the program-counter copies, the supervision word, the exception context, a version word and an interrupt mask/pending pair. It also drives an interrupt request and a one-cycle translation-flush strobe.

Reads are registered. `rd_data` and `rd_valid` appear on the clock edge that follows the cycle in which `rd_en` was high. An unmapped read hands back the caller's previous destination value. This lets the pipeline write the result to the destination without any special case.

Top module: `spr_file`

## Requirements
- R1: The register address is `base_addr | imm_off`. In group 0, the index selects the register: 0 version, 1 unit-present, 2 core config, 3 data-MMU config, 4 instruction-MMU config, 16 next PC, 17 supervision, 18 previous PC, 32 exception PC, 48 effective address, 64 saved status. In group 9 (address 0x4800 + index), index 0 is the interrupt mask and index 2 is the interrupt pending word.
- R2: Reset state: supervision word 0x0000_8001, with supervisor mode at bit 0 and the fixed-one bit at bit 15. Every other stored register is 0, except the version word, which takes `VER_RST`. `rd_valid`, `tlb_flush` and `irq_req` are 0.
- R3: A write to the supervision word stores the data with bit 15 forced to 1.
- R4: `tlb_flush` is high for exactly the cycle after a supervision write in which bit 0, bit 5 (data-MMU enable) or bit 6 (instruction-MMU enable) changes value. It stays low otherwise.
- R5: A write to the interrupt mask ORs the data into it. No write ever clears a mask bit.
- R6: A write to the pending word clears each bit whose data bit is 1. Each high `irq_lines` bit sets its pending bit. A set and a clear of the same bit in the same cycle leave it set.
- R7: `irq_req` is high exactly when (pending AND mask) is non-zero.
- R8: A read of an unmapped address returns `old_dst`. A write to an unmapped address changes no register.
- R9: `rd_data` and `rd_valid` are registered one cycle after `rd_en`. A read and a write in the same cycle return the value from before the write.
- R10: Unit-present and the three config words read as their parameter constants and ignore writes. The version word is writable.
- R11: Next PC, previous PC, exception PC, effective address and saved status each store and return the full written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Move-to strobe |
| rd_en | input | 1 | Move-from strobe |
| base_addr | input | 16 | Register-operand part of the address |
| imm_off | input | 16 | Immediate part of the address |
| wr_data | input | DW | Data to write |
| old_dst | input | DW | Current destination value, returned for unmapped reads |
| irq_lines | input | DW | Level interrupt sources, one per pending bit |
| rd_data | output | DW | Registered read result |
| rd_valid | output | 1 | Read result valid |
| sr_out | output | DW | Current supervision word |
| tlb_flush | output | 1 | One-cycle translation flush strobe |
| irq_req | output | 1 | Masked interrupt request |

## Verification
The assertions assume that `wr_en`, `rd_en`, the address halves, `irq_lines` and the data inputs are never unknown once reset is released. They also assume these inputs are held low during reset. The pending-clear property further assumes that `irq_lines` is sampled on the same edge as the write. The bench drives every input on the falling clock edge, from zero at reset. It raises interrupt lines only in chosen cycles, so each clear or set-wins case is applied deliberately rather than by chance.

// File: rtl/spr_file.sv
module spr_file #(
  parameter int          DW       = 32,
  parameter logic [31:0] VER_RST  = 32'h1200_0001,
  parameter logic [31:0] UPR_VAL  = 32'h0000_0619,
  parameter logic [31:0] CPU_CFG  = 32'h0000_0020,
  parameter logic [31:0] DMMU_CFG = 32'h0000_0018,
  parameter logic [31:0] IMMU_CFG = 32'h0000_0018
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [15:0]   base_addr,
  input  logic [15:0]   imm_off,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] old_dst,
  input  logic [DW-1:0] irq_lines,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [DW-1:0] sr_out,
  output logic          tlb_flush,
  output logic          irq_req
);
  localparam logic [15:0] A_VER = 16'd0,  A_UPR = 16'd1,  A_CCFG = 16'd2;
  localparam logic [15:0] A_DCFG = 16'd3, A_ICFG = 16'd4, A_NPC = 16'd16;
  localparam logic [15:0] A_SR = 16'd17,  A_PPC = 16'd18, A_EPC = 16'd32;
  localparam logic [15:0] A_EA = 16'd48,  A_ESR = 16'd64;
  localparam logic [15:0] A_MASK = 16'h4800, A_PEND = 16'h4802;
  localparam int SB_SM = 0, SB_DME = 5, SB_IME = 6, SB_FO = 15;
  localparam logic [DW-1:0] FO_BIT  = DW'(1) << SB_FO;
  localparam logic [DW-1:0] XL_BITS = (DW'(1) << SB_SM) | (DW'(1) << SB_DME) | (DW'(1) << SB_IME);
  localparam logic [DW-1:0] SR_RST  = FO_BIT | (DW'(1) << SB_SM);

  logic [15:0]   addr;
  logic [DW-1:0] ver, npc, sr, ppc, epc, ea, esr, mask, pend;
  logic [DW-1:0] rmux, clr;
  logic          hit;

  assign addr    = base_addr | imm_off;
  assign sr_out  = sr;
  assign irq_req = |(pend & mask);
  assign clr     = (wr_en && addr == A_PEND) ? wr_data : '0;

  always_comb begin
    hit  = 1'b1;
    rmux = old_dst;
    case (addr)
      A_VER:   rmux = ver;
      A_UPR:   rmux = DW'(UPR_VAL);
      A_CCFG:  rmux = DW'(CPU_CFG);
      A_DCFG:  rmux = DW'(DMMU_CFG);
      A_ICFG:  rmux = DW'(IMMU_CFG);
      A_NPC:   rmux = npc;
      A_SR:    rmux = sr;
      A_PPC:   rmux = ppc;
      A_EPC:   rmux = epc;
      A_EA:    rmux = ea;
      A_ESR:   rmux = esr;
      A_MASK:  rmux = mask;
      A_PEND:  rmux = pend;
      default: hit  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver <= DW'(VER_RST);
      npc <= '0; ppc <= '0; epc <= '0; ea <= '0; esr <= '0;
      sr  <= SR_RST;
      mask <= '0;
      tlb_flush <= 1'b0;
    end else begin
      tlb_flush <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_VER:  ver <= wr_data;
          A_NPC:  npc <= wr_data;
          A_PPC:  ppc <= wr_data;
          A_EPC:  epc <= wr_data;
          A_EA:   ea  <= wr_data;
          A_ESR:  esr <= wr_data;
          A_MASK: mask <= mask | wr_data;
          A_SR: begin
            sr <= wr_data | FO_BIT;
            tlb_flush <= |((sr ^ wr_data) & XL_BITS);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | irq_lines;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= hit ? rmux : old_dst;
    end
  end

  p_sr_fixed_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SR) |=> (sr == ($past(wr_data) | FO_BIT)));

  p_flush_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> ($past(wr_en) && $past(addr) == A_SR));

  p_mask_never_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask & $past(mask)) == $past(mask)));

  p_pend_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PEND) |=> ((pend & $past(wr_data) & ~$past(irq_lines)) == '0));

  p_unmapped_returns_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rd_data == $past(old_dst)));

  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: tb/spr_file_tb_top.sv
module spr_file_tb_top;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] base_addr = '0, imm_off = '0;
  logic [DW-1:0] wr_data = '0, old_dst = '0, irq_lines = '0;
  logic [DW-1:0] rd_data, sr_out;
  logic rd_valid, tlb_flush, irq_req;
  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  spr_file dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .base_addr(base_addr), .imm_off(imm_off), .wr_data(wr_data), .old_dst(old_dst),
    .irq_lines(irq_lines), .rd_data(rd_data), .rd_valid(rd_valid), .sr_out(sr_out),
    .tlb_flush(tlb_flush), .irq_req(irq_req));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; base_addr = a & 16'hFF00; imm_off = a & 16'h00FF; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] b, input logic [15:0] i, input logic [DW-1:0] old,
                    input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; base_addr = b; imm_off = i; old_dst = old;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rda(input logic [15:0] a, input logic [DW-1:0] exp, input string req);
    rd(a & 16'hFF00, a & 16'h00FF, 32'hA5A5_5A5A, exp, req);
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected valid", 1'b1, 1'b0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 rd_valid", rd_valid, 0);
    check("R2 tlb_flush", tlb_flush, 0);
    check("R2 irq_req", irq_req, 0);
    rst_n = 1'b1;
    rda(16'd17, 32'h0000_8001, "R2 sr reset");
    rda(16'd0, 32'h1200_0001, "R2 version reset");
    rda(16'd32, 32'h0, "R2 epc reset");
    rda(16'd1, 32'h0000_0619, "R10 unit-present");
    rda(16'd2, 32'h0000_0020, "R10 core cfg");
    rda(16'd3, 32'h0000_0018, "R10 dmmu cfg");
    rda(16'd4, 32'h0000_0018, "R10 immu cfg");
    wr(16'd1, 32'hFFFF_FFFF);
    rda(16'd1, 32'h0000_0619, "R10 unit-present ignores write");
    wr(16'd0, 32'h3456_7890);
    rda(16'd0, 32'h3456_7890, "R10 version writable");
    wr(16'd16, 32'h1111_0004); wr(16'd18, 32'h2222_0008);
    wr(16'd32, 32'h3333_000C); wr(16'd48, 32'hDEAD_BEEF); wr(16'd64, 32'h0000_8201);
    rda(16'd16, 32'h1111_0004, "R11 npc");
    rda(16'd18, 32'h2222_0008, "R11 ppc");
    rda(16'd32, 32'h3333_000C, "R11 epc");
    rda(16'd48, 32'hDEAD_BEEF, "R11 ea");
    rda(16'd64, 32'h0000_8201, "R11 esr");
    rd(16'h0011, 16'h0010, 32'h0, 32'h0000_8001, "R1 or-combined address");
    rd(16'h4800, 16'h0002, 32'h0, 32'h0, "R1 group 9 pending address");
    wr(16'd17, 32'h0000_0001);
    check("R4 no flush same xlate bits", tlb_flush, 0);
    rda(16'd17, 32'h0000_8001, "R3 fixed one forced");
    wr(16'd17, 32'h0000_0021);
    check("R4 flush on dme change", tlb_flush, 1);
    @(negedge clk);
    check("R4 flush one cycle", tlb_flush, 0);
    wr(16'd17, 32'h0000_0041);
    check("R4 flush on ime change", tlb_flush, 1);
    wr(16'd17, 32'h0000_7F41);
    check("R4 no flush other bits", tlb_flush, 0);
    check("R3 sr_out", sr_out, 32'h0000_FF41);
    wr(16'd17, 32'h0000_7F40);
    check("R4 flush on mode change", tlb_flush, 1);
    wr(16'h4800, 32'h0000_000F); wr(16'h4800, 32'h0000_00F0);
    rda(16'h4800, 32'h0000_00FF, "R5 mask or");
    wr(16'h4800, 32'h0);
    rda(16'h4800, 32'h0000_00FF, "R5 mask zero write keeps");
    @(negedge clk); irq_lines = 32'h0000_0100;
    @(negedge clk); irq_lines = 32'h0;
    check("R7 unmasked pending no req", irq_req, 0);
    irq_lines = 32'h0000_0001;
    @(negedge clk); irq_lines = 32'h0;
    check("R7 masked pending req", irq_req, 1);
    wr(16'h4802, 32'h0000_0001);
    check("R7 req drops after clear", irq_req, 0);
    rda(16'h4802, 32'h0000_0100, "R6 w1c leaves other bits");
    @(negedge clk);
    irq_lines = 32'h0000_0002; wr_en = 1'b1; base_addr = 16'h4800; imm_off = 16'h0002;
    wr_data = 32'h0000_0002;
    @(negedge clk); wr_en = 1'b0; irq_lines = 32'h0;
    rda(16'h4802, 32'h0000_0102, "R6 set wins over clear");
    wr(16'h4802, 32'h0000_0102);
    rda(16'h4802, 32'h0, "R6 clear all");
    rd(16'h0000, 16'h0005, 32'hCAFE_F00D, 32'hCAFE_F00D, "R8 unmapped read old_dst");
    rd(16'h0A00, 16'h0000, 32'h0BAD_0BAD, 32'h0BAD_0BAD, "R8 group 1 unmapped");
    wr(16'd5, 32'hFFFF_FFFF); wr(16'h0A00, 32'hFFFF_FFFF);
    rda(16'd17, 32'h0000_FF40, "R8 unmapped write no effect sr");
    rda(16'd48, 32'hDEAD_BEEF, "R8 unmapped write no effect ea");
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; base_addr = 16'h0; imm_off = 16'd32; wr_data = 32'h7777_7777;
    exp_q.push_back(32'h3333_000C); tag_q.push_back("R9 read before write");
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    rda(16'd32, 32'h7777_7777, "R9 write landed");
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule